// File: doc/BRIEF.md
# RDS Block Buffer Serial Read Port

This block holds up to 24 decoded RDS blocks, each 16 information bits plus its decoder flags. A host reads them back over a three-wire serial bus. The lines are a chip enable, a serial clock and a data-in line, and the block drives a data-out line. All bus lines are sampled by the block's own system clock, which must run several times faster than the serial clock.

Within one chip-enable frame the host first shifts in an 8-bit address. When the address selects the block, the block streams 32-bit words, oldest entry first, for as long as the host keeps clocking. Each word carries a marker, a set of flags and the 16 data bits. If the host stops partway through a word, the next frame sends that same word again. The exception is a word with only its last bit unread, which counts as consumed. When nothing is left to read, every word is all zeros.

Upstream logic writes entries through a single-cycle push strobe. A push into a full buffer replaces the oldest entry. A synchronous active-high reset empties the buffer and returns the bus logic to idle.

Top module: `rds_readout_port`

## Requirements
- R1: Address bits are taken on serial-clock rising edges while chip enable is high, least-significant bit first. Only the value 0x6C selects the block. With any other address, data-out stays low for the whole frame and no entry is consumed.
- R2: Bits go out MSB first. A word for a buffered entry has this layout:
  - bits 31..28: 1010
  - bit 27: offset-detected flag
  - bits 26..24: offset identity
  - bit 23: burst flag
  - bit 22: remaining flag
  - bit 21: ARI flag
  - bit 20: sync flag
  - bits 19..17: error flags
  - bit 16: zero
  - bits 15..0: data
- R3: Any number of words can be read back to back in one frame, in the order the entries were pushed.
- R4: When the buffer holds no entry, the word sent is 32 zero bits.
- R5: If chip enable drops after fewer than 31 bits of a word have been clocked, the entry is kept. The next selected frame sends that same word first.
- R6: The entry is consumed on the 31st rising edge of its word. A frame that ends after exactly 31 bits therefore resumes at the next entry.
- R7: Data-out is low while chip enable is low.
- R8: A push into a buffer holding 24 entries discards the oldest entry, and the count stays at 24.
- R9: The remaining flag (bit 22) is 1 when more than one entry is unread at the time the word is loaded. The burst flag (bit 23) is 1 when at least three are unread.
- R10: Reset empties the buffer, so the words that follow are all zero.
- R11: Data-out changes only after serial-clock falling edges and holds its value across the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | Push strobe for one entry |
| wrInfo | input | 16 | RDS information bits |
| wrOffsetSeen | input | 1 | Offset word detected |
| wrOffsetId | input | 3 | Offset identity code |
| wrAriSeen | input | 1 | ARI detect flag |
| wrSyncOk | input | 1 | Sync established flag |
| wrErr | input | 3 | Error flags E2..E0 |
| busClk | input | 1 | Serial clock |
| busEn | input | 1 | Chip enable, active high |
| busIn | input | 1 | Serial data in |
| busOut | output | 1 | Serial data out |

## Verification
The assertions check the following on every cycle:
- the occupancy bound and the fixed count when a push overwrites a full buffer;
- the marker in each loaded entry word and the all-zero word loaded from an empty buffer;
- that data-out goes quiet when chip enable drops;
- that selection is only ever granted on the eighth address bit.

Some behaviour shows only across frames, so only the bench scenarios can demonstrate it:
- re-reading a word after an early cut;
- consumption at the 31st bit;
- rejection of the bit-reversed address;
- the remaining and burst flags as the buffer drains.

// File: rtl/rds_rd_pkg.sv
package rds_rd_pkg;

  localparam int WORD_BITS = 32;
  localparam logic [3:0] WORD_MARK = 4'b1010;

  typedef struct packed {
    logic        offsetSeen;
    logic [2:0]  offsetId;
    logic        ariSeen;
    logic        syncOk;
    logic [2:0]  errLvl;
    logic [15:0] info;
  } rdsEntry_t;

  typedef struct packed {
    logic loadWord;
    logic shiftWord;
    logic popEntry;
  } bufStrobe_t;

endpackage

// File: rtl/rds_rd_ctrl.sv
module rds_rd_ctrl
  import rds_rd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_VAL = 8'h6C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busClk,
  input  logic       busEn,
  input  logic       busIn,
  output bufStrobe_t strobe,
  output logic       outEn
);

  localparam int ACNT_W = $clog2(ADDR_W + 1);
  localparam int BCNT_W = $clog2(WORD_BITS);
  localparam logic [ACNT_W-1:0] ADDR_LAST = ACNT_W'(ADDR_W - 1);
  localparam logic [ACNT_W-1:0] ADDR_DONE = ACNT_W'(ADDR_W);
  localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(WORD_BITS - 1);
  localparam logic [BCNT_W-1:0] BIT_COMMIT = BCNT_W'(WORD_BITS - 2);

  logic              sclkQ;
  logic [ADDR_W-1:0] addrSr;
  logic [ACNT_W-1:0] addrCnt;
  logic              selected;
  logic [BCNT_W-1:0] bitCnt;
  logic              rise, fall;
  logic [ADDR_W-1:0] addrNext;

  assign rise     = busEn & busClk & ~sclkQ;
  assign fall     = busEn & ~busClk & sclkQ;
  assign addrNext = {busIn, addrSr[ADDR_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ    <= 1'b0;
      addrSr   <= '0;
      addrCnt  <= '0;
      selected <= 1'b0;
      bitCnt   <= '0;
      outEn    <= 1'b0;
    end else begin
      sclkQ <= busClk;
      if (!busEn) begin
        addrSr   <= '0;
        addrCnt  <= '0;
        selected <= 1'b0;
        bitCnt   <= '0;
        outEn    <= 1'b0;
      end else begin
        if (rise && addrCnt != ADDR_DONE) begin
          addrSr  <= addrNext;
          addrCnt <= addrCnt + 1'b1;
          if (addrCnt == ADDR_LAST) selected <= (addrNext == ADDR_VAL);
        end else if (rise && selected && outEn) begin
          bitCnt <= (bitCnt == BIT_LAST) ? '0 : bitCnt + 1'b1;
        end
        if (fall && selected) outEn <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadWord  = fall & selected & (bitCnt == '0);
    strobe.shiftWord = fall & selected & (bitCnt != '0);
    strobe.popEntry  = rise & selected & outEn & (bitCnt == BIT_COMMIT);
  end

  // R1: selection can only be granted on the final address bit
  assert_select_on_last_bit_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(selected) |-> ($past(addrCnt) == ADDR_LAST));

  // R7: dropping chip enable disables the output stage
  assert_en_drop_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !busEn |=> !outEn);

endmodule

// File: rtl/rds_rd_buf.sv
module rds_rd_buf
  import rds_rd_pkg::*;
#(
  parameter int DEPTH = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrValid,
  input  rdsEntry_t  wrEntry,
  input  bufStrobe_t strobe,
  output logic       shiftMsb
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);

  rdsEntry_t            mem [DEPTH];
  logic [PTR_W-1:0]     head, tail;
  logic [CNT_W-1:0]     count;
  logic [WORD_BITS-1:0] shreg, wordNext;
  logic                 popArmed;
  logic                 full, doPop, overwrite, grow;
  rdsEntry_t            headEntry;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_FULL);
  assign doPop     = strobe.popEntry & popArmed & (count != '0);
  assign overwrite = wrValid & full & ~doPop;
  assign grow      = wrValid & (~full | doPop);
  assign headEntry = mem[head];
  assign shiftMsb  = shreg[WORD_BITS-1];

  always_comb begin
    if (count == '0) begin
      wordNext = '0;
    end else begin
      wordNext = {WORD_MARK, headEntry.offsetSeen, headEntry.offsetId,
                  (count > CNT_TWO), (count >= CNT_TWO),
                  headEntry.ariSeen, headEntry.syncOk, headEntry.errLvl,
                  1'b0, headEntry.info};
    end
  end

  always_ff @(posedge clk) begin
    if (wrValid) mem[tail] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      shreg    <= '0;
      popArmed <= 1'b0;
    end else begin
      if (wrValid) tail <= ptrInc(tail);
      if (doPop || overwrite) head <= ptrInc(head);
      if (grow && !doPop)      count <= count + 1'b1;
      else if (!grow && doPop) count <= count - 1'b1;

      if (strobe.loadWord)        popArmed <= (count != '0);
      else if (doPop || overwrite) popArmed <= 1'b0;

      if (strobe.loadWord)       shreg <= wordNext;
      else if (strobe.shiftWord) shreg <= {shreg[WORD_BITS-2:0], 1'b0};
    end
  end

  // R8: occupancy never exceeds the buffer depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL);

  // R8: a push into a full buffer keeps it full
  assert_full_push_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (wrValid && full && !strobe.popEntry) |=> (count == CNT_FULL));

  // R2: every word loaded from a held entry starts with the marker
  assert_marker_on_load_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadWord && count != '0) |=> (shreg[WORD_BITS-1 -: 4] == WORD_MARK));

  // R4: an empty buffer loads an all-zero word
  assert_empty_word_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadWord && count == '0 && !wrValid) |=> (shreg == '0));

endmodule

// File: rtl/rds_readout_port.sv
module rds_readout_port
  import rds_rd_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_VAL = 8'h6C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrValid,
  input  logic [15:0] wrInfo,
  input  logic        wrOffsetSeen,
  input  logic [2:0]  wrOffsetId,
  input  logic        wrAriSeen,
  input  logic        wrSyncOk,
  input  logic [2:0]  wrErr,
  input  logic        busClk,
  input  logic        busEn,
  input  logic        busIn,
  output logic        busOut
);

  bufStrobe_t strobe;
  rdsEntry_t  wrEntry;
  logic       outEn;
  logic       shiftMsb;

  assign wrEntry = '{offsetSeen: wrOffsetSeen, offsetId: wrOffsetId,
                     ariSeen: wrAriSeen, syncOk: wrSyncOk,
                     errLvl: wrErr, info: wrInfo};

  rds_rd_ctrl #(.ADDR_W(ADDR_W), .ADDR_VAL(ADDR_VAL)) u_ctrl (
    .clk(clk), .rst(rst), .busClk(busClk), .busEn(busEn), .busIn(busIn),
    .strobe(strobe), .outEn(outEn)
  );

  rds_rd_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrEntry(wrEntry),
    .strobe(strobe), .shiftMsb(shiftMsb)
  );

  assign busOut = outEn & shiftMsb;

  // R7: data-out is quiet one cycle after chip enable is low
  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busEn |=> !busOut);

endmodule

// File: tb/rds_readout_port_tb.sv
`timescale 1ns/1ps
module rds_readout_port_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrValid = 1'b0;
  logic [15:0] wrInfo = '0;
  logic wrOffsetSeen = 1'b0;
  logic [2:0] wrOffsetId = '0;
  logic wrAriSeen = 1'b0;
  logic wrSyncOk = 1'b0;
  logic [2:0] wrErr = '0;
  logic busClk = 1'b0;
  logic busEn = 1'b0;
  logic busIn = 1'b0;
  logic busOut;

  always #2.5 clk = ~clk;

  rds_readout_port u_dut (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrInfo(wrInfo),
    .wrOffsetSeen(wrOffsetSeen), .wrOffsetId(wrOffsetId),
    .wrAriSeen(wrAriSeen), .wrSyncOk(wrSyncOk), .wrErr(wrErr),
    .busClk(busClk), .busEn(busEn), .busIn(busIn), .busOut(busOut)
  );

  int nChecks = 0;
  int nErr = 0;

  // bench reference model: entry = {offsetSeen, id[2:0], ari, sync, err[2:0], info[15:0]}
  logic [24:0] mq [24];
  int mHead = 0, mTail = 0, mCnt = 0;

  localparam logic [24:0] VEC [6] = '{
    {1'b1, 3'd0, 1'b0, 1'b1, 3'd0, 16'h1234},
    {1'b1, 3'd1, 1'b1, 1'b1, 3'd2, 16'hA5C3},
    {1'b0, 3'd2, 1'b0, 1'b0, 3'd7, 16'h0F0F},
    {1'b1, 3'd3, 1'b1, 1'b0, 3'd1, 16'hFFFF},
    {1'b1, 3'd4, 1'b0, 1'b1, 3'd5, 16'h8001},
    {1'b0, 3'd6, 1'b1, 1'b1, 3'd3, 16'h0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord();
    logic [24:0] e;
    if (mCnt == 0) return 32'h0;
    e = mq[mHead];
    return {4'b1010, e[24], e[23:21], (mCnt >= 3), (mCnt > 1),
            e[20], e[19], e[18:16], 1'b0, e[15:0]};
  endfunction

  task automatic modelPop();
    if (mCnt > 0) begin
      mHead = (mHead + 1) % 24;
      mCnt--;
    end
  endtask

  task automatic push(input logic [24:0] e);
    wrOffsetSeen = e[24]; wrOffsetId = e[23:21]; wrAriSeen = e[20];
    wrSyncOk = e[19]; wrErr = e[18:16]; wrInfo = e[15:0];
    wrValid = 1'b1;
    tick(1);
    wrValid = 1'b0;
    mq[mTail] = e;
    mTail = (mTail + 1) % 24;
    if (mCnt == 24) mHead = (mHead + 1) % 24;
    else mCnt++;
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(2);
    mHead = 0; mTail = 0; mCnt = 0;
  endtask

  task automatic sendAddr(input logic [7:0] a);
    busEn = 1'b1;
    tick(2);
    for (int i = 0; i < 8; i++) begin
      busIn = a[i];
      tick(2);
      busClk = 1'b1; tick(4);
      busClk = 1'b0; tick(4);
    end
    busIn = 1'b0;
  endtask

  task automatic readBits(input int n, output logic [31:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      w = {w[30:0], busOut};
      busClk = 1'b1; tick(4);
      busClk = 1'b0; tick(4);
    end
  endtask

  task automatic endFrame();
    busEn = 1'b0;
    tick(4);
  endtask

  initial begin
    #(200000 * 5);
    nErr++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] w, exp;
    logic b0;
    tick(4);
    rst = 1'b0;
    tick(2);

    // R7: reset state, output quiet
    check("R7 reset quiet", {31'b0, busOut}, 32'h0);

    // R4: empty buffer streams zero words
    sendAddr(8'h6C);
    readBits(32, w); check("R4 empty word 1", w, 32'h0);
    readBits(32, w); check("R4 empty word 2", w, 32'h0);
    endFrame();

    // table walk: R3 order, R2 layout, R9 flags while draining
    foreach (VEC[k]) push(VEC[k]);
    sendAddr(8'h6C);
    for (int k = 0; k < 7; k++) begin
      exp = expWord();
      readBits(32, w);
      check(k == 6 ? "R4 drained word" : "R3 R2 R9 table word", w, exp);
      modelPop();
    end
    endFrame();
    // R7: quiet after frame end
    check("R7 quiet after frame", {31'b0, busOut}, 32'h0);

    // R1: bit-reversed address (0x36) must not select; no entry consumed
    push(VEC[1]); push(VEC[2]); push(VEC[3]);
    sendAddr(8'h36);
    readBits(32, w);
    check("R1 wrong address silent", w, 32'h0);
    endFrame();
    sendAddr(8'h6C);
    exp = expWord();
    // R11: output holds across a rising serial edge
    b0 = busOut;
    busClk = 1'b1; tick(4);
    check("R11 stable over rise", {31'b0, busOut}, {31'b0, b0});
    busClk = 1'b0; tick(4);
    check("R1 first bit after select", {31'b0, b0}, {31'b0, exp[31]});
    endFrame();

    // R5: cut after 20 bits, word repeats
    sendAddr(8'h6C);
    exp = expWord();
    readBits(20, w);
    check("R5 partial bits", w, {12'h0, exp[31:12]});
    endFrame();
    sendAddr(8'h6C);
    readBits(32, w);
    check("R5 word reread", w, exp);
    endFrame();
    // after a full word the entry is gone
    modelPop();

    // R6: cut after exactly 31 bits consumes the entry
    sendAddr(8'h6C);
    readBits(31, w);
    endFrame();
    modelPop();
    sendAddr(8'h6C);
    exp = expWord();
    readBits(32, w);
    check("R6 next entry after 31 bits", w, exp);
    modelPop();
    readBits(32, w);
    check("R4 zero after last", w, 32'h0);
    endFrame();

    // R8: overflow drops the two oldest of 26
    doReset();
    for (int k = 0; k < 26; k++)
      push({1'b1, 3'(k % 5), 1'b0, 1'b1, 3'd0, 16'(16'h4000 + k)});
    sendAddr(8'h6C);
    exp = expWord();
    readBits(32, w);
    check("R8 oldest overwritten", w, exp);
    check("R8 data of first survivor", {16'h0, w[15:0]}, 32'h4002);
    modelPop();
    exp = expWord();
    readBits(32, w);
    check("R8 second survivor", w, exp);
    modelPop();
    endFrame();

    // R10: reset empties the buffer
    doReset();
    push(VEC[0]); push(VEC[4]);
    doReset();
    sendAddr(8'h6C);
    readBits(32, w);
    check("R10 zero after reset", w, 32'h0);
    endFrame();

    // R9: single entry -> remaining=0, burst=0
    push(VEC[3]);
    sendAddr(8'h6C);
    readBits(32, w);
    check("R9 lone entry flags", {30'h0, w[23:22]}, 32'h0);
    endFrame();

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule